// File: doc/BRIEF.md
# Stepper Motor Excitation Sequencer

This block produces the four on/off drive commands for the windings of a unipolar two-phase stepping motor. The two ends of winding A are driven by `drv_a` and `drv_a_n`; the two ends of winding B are driven by `drv_b` and `drv_b_n`. Every accepted edge of an external step clock moves the rotor one position forward or backward. A step can be a full step, where two windings are always energised, or a half step, where single-winding states are placed between the two-winding states. The step clock can be taken on its rising edges only or on both edges. A direction input selects forward or reverse.

Every control input is asynchronous and passes through a two-flop synchroniser clocked by a fast system clock. The position is kept as a three-bit index into an eight-entry half-step cycle. The index survives mode changes and survives periods when the output enable is low. While the enable is low, the block still counts step edges and keeps the drive commands off. When the step clock stops, the last excitation state stays driven, so the motor holds its position. The four outputs are on/off commands for a later current-chopping stage.

Top module: `stepper_phase_seq`

## Requirements
- R1: While `rst_n` is low, all four drive outputs are 0 and the position returns to its start. After release with `drv_en` high, the first driven state is `drv_a` with `drv_b_n` (output vector {drv_a, drv_a_n, drv_b, drv_b_n} = 4'b1001).
- R2: With `half_step` low and `reverse` low, each accepted step visits the two-winding states in this order, as {drv_a, drv_a_n, drv_b, drv_b_n}: 1001, 1010, 0110, 0101, then back to 1001.
- R3: With `half_step` high and `reverse` low, each accepted step visits all eight states in this order: 1001, 1000, 1010, 0010, 0110, 0100, 0101, 0001, then back to 1001.
- R4: With `reverse` high, the same cycles are walked in the opposite order.
- R5: With `rise_only` high, only rising edges of `step_clk` are accepted. A falling edge leaves the outputs unchanged.
- R6: With `rise_only` low, both rising and falling edges of `step_clk` are accepted as steps.
- R7: While `drv_en` is low, all four outputs are 0 and accepted steps still move the position. When `drv_en` returns high, the outputs show the state that was reached.
- R8: A change of `half_step` keeps the current position. In full-step mode, a step from a single-winding state moves to the adjacent two-winding state in the direction of travel.
- R9: When no step edge arrives, the driven state is held unchanged.
- R10: `drv_a` and `drv_a_n` are never 1 together, and `drv_b` and `drv_b_n` are never 1 together.
- R11: A change on `step_clk` that is applied between two system-clock edges shows at the outputs after the fourth rising system-clock edge that follows. It does not show after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the step clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| step_clk | input | 1 | Asynchronous step clock |
| half_step | input | 1 | 0 selects full-step excitation, 1 selects half-step excitation |
| rise_only | input | 1 | 1 accepts rising edges only, 0 accepts both edges |
| reverse | input | 1 | 0 runs forward, 1 runs in reverse |
| drv_en | input | 1 | 1 drives the windings, 0 blanks all four outputs |
| drv_a | output | 1 | Drive command, winding A, first end |
| drv_a_n | output | 1 | Drive command, winding A, second end |
| drv_b | output | 1 | Drive command, winding B, first end |
| drv_b_n | output | 1 | Drive command, winding B, second end |

## Verification
The stepping function is run with rising-only and dual-edge step clocks, in full-step and half-step mode, forward and in reverse. Each pattern is compared with the state order written in its requirement, so a wrong order, a wrong step size or a lost edge shows up as a specific wrong state. A mode change is made while the rotor sits on a single-winding state, which separates a design that keeps the position from one that restarts or stays on odd states. Steps are also sent with the enable low, which separates blanking from freezing the counter. A timed edge probe pins the synchroniser latency to exactly four system-clock edges.

// File: rtl/stepper_seq_pkg.sv
package stepper_seq_pkg;
  localparam int POS_W = 3;
  localparam int NPOS  = 1 << POS_W;

  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    logic a;
    logic a_n;
    logic b;
    logic b_n;
  } drive_t;

  // Eight-entry half-step cycle; even positions energise two windings.
  function automatic drive_t drive_of(pos_t p);
    drive_t d;
    d.a   = (p <= pos_t'(2));
    d.a_n = (p >= pos_t'(4)) && (p <= pos_t'(6));
    d.b   = (p >= pos_t'(2)) && (p <= pos_t'(4));
    d.b_n = (p >= pos_t'(6)) || (p == pos_t'(0));
    return d;
  endfunction
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else        st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else        st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/step_edge_det.sv
module step_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_only,
  output logic step
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  always_comb begin
    step = (lvl && !prev) || (!rise_only && !lvl && prev);
  end
endmodule

// File: rtl/phase_pos_ctr.sv
module phase_pos_ctr
  import stepper_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic half,
  input  logic rev,
  output pos_t pos
);
  pos_t nxt;
  pos_t inc;

  always_comb begin
    if (half || pos[0]) inc = pos_t'(1);
    else                inc = pos_t'(2);
    nxt = rev ? (pos - inc) : (pos + inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (clr)  pos <= '0;
    else if (step) pos <= nxt;
  end
endmodule

// File: rtl/phase_drive_out.sv
module phase_drive_out
  import stepper_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   en,
  input  pos_t   pos,
  output drive_t drv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          drv <= '0;
    else if (clr || !en) drv <= '0;
    else                 drv <= drive_of(pos);
  end
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_clk,
  input  logic half_step,
  input  logic rise_only,
  input  logic reverse,
  input  logic drv_en,
  output logic drv_a,
  output logic drv_a_n,
  output logic drv_b,
  output logic drv_b_n
);
  localparam int NIN = 5;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] syn_in;
  logic           rst_sync_n;
  logic           seq_clr;
  logic           stp_s, half_s, rise_s, rev_s, en_s;
  logic           step_pulse;
  pos_t           pos_idx;
  drive_t         drv;

  assign raw_in = {step_clk, half_step, rise_only, reverse, drv_en};

  seq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  seq_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign {stp_s, half_s, rise_s, rev_s, en_s} = syn_in;
  assign seq_clr = !rst_sync_n;

  step_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(stp_s), .rise_only(rise_s), .step(step_pulse)
  );

  phase_pos_ctr u_pos (
    .clk(clk), .rst_n(rst_n), .clr(seq_clr), .step(step_pulse),
    .half(half_s), .rev(rev_s), .pos(pos_idx)
  );

  phase_drive_out u_out (
    .clk(clk), .rst_n(rst_n), .clr(seq_clr), .en(en_s), .pos(pos_idx), .drv(drv)
  );

  assign drv_a   = drv.a;
  assign drv_a_n = drv.a_n;
  assign drv_b   = drv.b;
  assign drv_b_n = drv.b_n;
endmodule

// File: rtl/stepper_phase_seq_chk.sv
module stepper_phase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       seq_clr,
  input logic       en_s,
  input logic       step,
  input logic       half_s,
  input logic       rev_s,
  input logic [2:0] idx,
  input logic       o_a,
  input logic       o_a_n,
  input logic       o_b,
  input logic       o_b_n
);
  assert_winding_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(o_a && o_a_n) && !(o_b && o_b_n));

  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !(o_a || o_a_n || o_b || o_b_n));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !seq_clr) |=> $stable(idx));

  assert_full_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !half_s && !seq_clr) |=> !idx[0]);

  assert_half_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && half_s && !rev_s && !seq_clr) |=> (idx == 3'($past(idx) + 3'd1)));

  assert_reverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && half_s && rev_s && !seq_clr) |=> (idx == 3'($past(idx) - 3'd1)));

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clr |=> (idx == 3'd0) && !(o_a || o_a_n || o_b || o_b_n));
endmodule

bind stepper_phase_seq stepper_phase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .seq_clr(seq_clr), .en_s(en_s), .step(step_pulse),
  .half_s(half_s), .rev_s(rev_s), .idx(pos_idx),
  .o_a(drv_a), .o_a_n(drv_a_n), .o_b(drv_b), .o_b_n(drv_b_n)
);

// File: tb/test_stepper_phase_seq.sv
`timescale 1ns/1ps
module test_stepper_phase_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, step_clk = 1'b0, half_step = 1'b0, rise_only = 1'b1;
  logic reverse = 1'b0, drv_en = 1'b1;
  logic drv_a, drv_a_n, drv_b, drv_b_n;

  stepper_phase_seq i_stepper_phase_seq (
    .clk(clk), .rst_n(rst_n), .step_clk(step_clk), .half_step(half_step),
    .rise_only(rise_only), .reverse(reverse), .drv_en(drv_en),
    .drv_a(drv_a), .drv_a_n(drv_a_n), .drv_b(drv_b), .drv_b_n(drv_b_n)
  );

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  int mpos = 0;
  bit done = 0;

  // Expected states from R3: {a, a_n, b, b_n} per half-step position
  function automatic logic [3:0] exp_of(int p);
    case (p)
      0: return 4'b1001; 1: return 4'b1000; 2: return 4'b1010; 3: return 4'b0010;
      4: return 4'b0110; 5: return 4'b0100; 6: return 4'b0101; default: return 4'b0001;
    endcase
  endfunction

  function automatic void model_step();
    int inc;
    inc = (half_step || (mpos % 2 == 1)) ? 1 : 2;
    mpos = reverse ? (mpos - inc + 8) % 8 : (mpos + inc) % 8;
  endfunction

  task automatic push(logic [3:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk(string tag);
    push(drv_en ? exp_of(mpos) : 4'b0000, tag);
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    #1;
  endtask

  // counted edge: toggle level and update model if the edge is accepted
  task automatic edge_to(logic v);
    @(negedge clk) step_clk = v;
    if (v || !rise_only) model_step();
    settle();
  endtask

  always @(negedge clk) begin
    item_t it;
    if (q.size() > 0) begin
      it = q.pop_front();
      n_run++;
      if ({drv_a, drv_a_n, drv_b, drv_b_n} !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b", it.tag,
                 {drv_a, drv_a_n, drv_b, drv_b_n}, it.exp);
      end
      n_run++;
      if ((drv_a && drv_a_n) || (drv_b && drv_b_n)) begin
        n_fail++;
        $display("FAIL R10 (%s): got %b expected no opposing ends", it.tag,
                 {drv_a, drv_a_n, drv_b, drv_b_n});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    settle();
    push(4'b0000, "R1 outputs off in reset");
    rst_n = 1'b1;
    settle();
    push(4'b1001, "R1 first state A+BB");

    // R2 full-step forward, rising only; R5 falling ignored
    for (int i = 0; i < 4; i++) begin
      edge_to(1'b1); chk("R2 full-step forward");
      edge_to(1'b0); chk("R5 falling edge ignored");
    end

    // R9 hold with no edges
    repeat (50) @(posedge clk);
    #1; chk("R9 state held");

    // R3 half-step forward
    half_step = 1'b1; settle();
    for (int i = 0; i < 8; i++) begin
      edge_to(1'b1); chk("R3 half-step forward");
      edge_to(1'b0);
    end

    // R4 reverse, half then full
    reverse = 1'b1; settle();
    for (int i = 0; i < 3; i++) begin
      edge_to(1'b1); chk("R4 half-step reverse");
      edge_to(1'b0);
    end
    // now on odd position: R8 mode change keeps position
    half_step = 1'b0; settle();
    chk("R8 position kept over mode change");
    edge_to(1'b1); chk("R8 full step snaps to two-winding state");
    edge_to(1'b0);
    edge_to(1'b1); chk("R4 full-step reverse");
    edge_to(1'b0);

    // R6 dual edge
    reverse = 1'b0; rise_only = 1'b0; half_step = 1'b1; settle();
    for (int i = 0; i < 4; i++) begin
      edge_to(1'b1); chk("R6 rising edge accepted");
      edge_to(1'b0); chk("R6 falling edge accepted");
    end
    edge_to(1'b1); chk("R6 rising edge accepted");
    // odd position, forward full-step snap R8
    half_step = 1'b0; settle();
    edge_to(1'b0); chk("R8 forward snap to two-winding state");

    // R7 enable blanking with tracking
    drv_en = 1'b0; settle();
    chk("R7 outputs blanked");
    edge_to(1'b1); chk("R7 blanked during step");
    edge_to(1'b0);
    drv_en = 1'b1; settle();
    chk("R7 resumes at reached state");

    // R11 latency: four system edges
    rise_only = 1'b1; settle();
    @(negedge clk) step_clk = 1'b1;
    repeat (3) @(posedge clk);
    #1; push(exp_of(mpos), "R11 unchanged after three edges");
    @(posedge clk); #1;
    model_step();
    push(exp_of(mpos), "R11 updated after fourth edge");
    @(negedge clk) step_clk = 1'b0;
    settle();

    // R1 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    #1; push(4'b0000, "R1 outputs off at reset");
    settle();
    push(4'b0000, "R1 outputs off held in reset");
    rst_n = 1'b1; mpos = 0;
    settle();
    chk("R1 restart at A+BB");

    settle();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule